// File: doc/BRIEF.md
# Repeated Trace Dispatch Detector

This block lives in the trace fetch stage of a processor. It records the identity of every dispatched trace line (start address plus branch-outcome bits) in a short ordered shift register. In the same cycle as the trace cache lookup, it compares the trace being fetched against the newest recorded dispatch. If the same trace is about to be dispatched twice in a row, the block has found a loop body that can be issued as a vector.

A trace can be a candidate only when it starts at a backward-branch target and ends with that same backward branch. On an eligible repeat, the block raises a combinational hit. When that trace is dispatched, it produces a registered vectorize flag together with the trace address.

A small controller then tells fetch to follow the predicted loop-exit path. While it does so, further dispatches of the same trace are not vectorized again. The controller has three states:

- `ST_EMPTY`: reset; nothing recorded.
- `ST_TRACK`: history is live and repeats are looked for.
- `ST_LOOP`: a loop has been captured.

Its transitions are:

- Any dispatch moves `ST_EMPTY` to `ST_TRACK`.
- A dispatch with an eligible hit moves `ST_TRACK` to `ST_LOOP`.
- A dispatch of a different trace moves `ST_LOOP` back to `ST_TRACK`.
- A dispatch of the same trace keeps `ST_LOOP`.

Top module: `trace_repeat_detect`

## Requirements
- R1: After reset, all history entries are invalid, and `oldest_valid`, `repeat_hit`, `vec_flag` and `exit_path` are all 0.
- R2: A dispatch (`fetch_valid` and `dispatch` both 1) shifts `{fetch_addr, fetch_br}` into the newest slot. Entries leave through `oldest_*` in dispatch order, exactly `HIST_DEPTH` dispatches after entering.
- R3: In a cycle without a dispatch, the history does not change.
- R4: `repeat_hit` is 1 in the same cycle when all of the following hold: the fetched address and branch bits equal the newest valid entry, both `fetch_bwd_start` and `fetch_bwd_end` are 1, and the controller is not in `ST_LOOP`.
- R5: If the address or any branch-outcome bit differs from the newest entry, `repeat_hit` is 0.
- R6: If either backward-branch boundary flag is 0, `repeat_hit` is 0.
- R7: Only the newest entry is compared. A trace equal to an older entry, but not to the newest, gives no hit.
- R8: `vec_flag` is 1 for the single cycle after a dispatch with `repeat_hit` 1, and `vec_addr` then holds that dispatch's address. Otherwise `vec_flag` is 0.
- R9: After a vectorize, `exit_path` is 1 and further dispatches of the same trace raise neither `repeat_hit` nor `vec_flag`. A dispatch of a different trace clears `exit_path`.
- R10: With `fetch_valid` 0, `repeat_hit` is 0 and nothing is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A trace is being fetched this cycle |
| fetch_addr | input | ADDR_W | Start address of the fetched trace |
| fetch_br | input | BR_W | Branch-outcome bits of the fetched trace |
| fetch_bwd_start | input | 1 | Trace begins at a backward-branch target |
| fetch_bwd_end | input | 1 | Trace ends with the matching backward branch |
| dispatch | input | 1 | The fetched trace is dispatched this cycle |
| repeat_hit | output | 1 | Combinational eligible repeat of the newest dispatch |
| vec_flag | output | 1 | Registered vectorize decision for the dispatched trace |
| vec_addr | output | ADDR_W | Address of the vectorized trace |
| exit_path | output | 1 | Fetch should follow the predicted loop-exit path |
| oldest_valid | output | 1 | Valid bit of the oldest history slot |
| oldest_addr | output | ADDR_W | Address in the oldest history slot |
| oldest_br | output | BR_W | Branch bits in the oldest history slot |

## Verification
A sweep over every 4-bit address and 2-bit branch pattern first records a trace. It then probes that trace with four kinds of variant:

- the address changed, or one branch bit changed, which separates a full key compare from an address-only compare;
- each boundary flag dropped on its own, which shows that eligibility needs both ends;
- fetch-valid dropped, which shows that an idle fetch cannot hit;
- an exact eligible repeat.

The sweep then dispatches the repeat twice more and follows with a foreign trace. This tells a one-time vectorize apart from one that repeats on every iteration, and shows that the loop-exit state is released. A short directed run places a trace two entries back in the history, which separates a compare against the newest entry from a search over the whole history. A run of idle cycles confirms that the oldest slot only moves when a dispatch happens.

// File: rtl/trd_pkg.sv
package trd_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_TRACK = 2'd1,
        ST_LOOP  = 2'd2
    } trd_state_e;
endpackage

// File: rtl/trd_history.sv
module trd_history #(
    parameter int ADDR_W = 32,
    parameter int BR_W   = 4,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BR_W-1:0]   in_br,
    output logic              new_valid,
    output logic [ADDR_W-1:0] new_addr,
    output logic [BR_W-1:0]   new_br,
    output logic              old_valid,
    output logic [ADDR_W-1:0] old_addr,
    output logic [BR_W-1:0]   old_br
);
    localparam int LAST = DEPTH - 1;

    logic              v_q [DEPTH];
    logic [ADDR_W-1:0] a_q [DEPTH];
    logic [BR_W-1:0]   b_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q[g] <= 1'b0;
                    a_q[g] <= '0;
                    b_q[g] <= '0;
                end else if (shift_en) begin
                    v_q[g] <= 1'b1;
                    a_q[g] <= in_addr;
                    b_q[g] <= in_br;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q[g] <= 1'b0;
                    a_q[g] <= '0;
                    b_q[g] <= '0;
                end else if (shift_en) begin
                    v_q[g] <= v_q[g-1];
                    a_q[g] <= a_q[g-1];
                    b_q[g] <= b_q[g-1];
                end
            end
        end
    end

    assign new_valid = v_q[0];
    assign new_addr  = a_q[0];
    assign new_br    = b_q[0];
    assign old_valid = v_q[LAST];
    assign old_addr  = a_q[LAST];
    assign old_br    = b_q[LAST];
endmodule

// File: rtl/trd_match.sv
module trd_match #(
    parameter int ADDR_W = 32,
    parameter int BR_W   = 4
) (
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [BR_W-1:0]   fetch_br,
    input  logic              bwd_start,
    input  logic              bwd_end,
    input  logic              ent_valid,
    input  logic [ADDR_W-1:0] ent_addr,
    input  logic [BR_W-1:0]   ent_br,
    output logic              same_key,
    output logic              elig_hit
);
    logic addr_eq;
    logic br_eq;

    always_comb begin
        addr_eq  = (fetch_addr == ent_addr);
        br_eq    = (fetch_br == ent_br);
        same_key = fetch_valid && ent_valid && addr_eq && br_eq;
        elig_hit = same_key && bwd_start && bwd_end;
    end
endmodule

// File: rtl/trd_ctrl.sv
module trd_ctrl
    import trd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp,
    input  logic              same_key,
    input  logic              elig_hit,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              hit_ok,
    output logic              exit_path,
    output logic              vec_flag,
    output logic [ADDR_W-1:0] vec_addr
);
    trd_state_e state_q;
    trd_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (disp) state_d = ST_TRACK;
            ST_TRACK: if (disp && elig_hit) state_d = ST_LOOP;
            ST_LOOP:  if (disp && !same_key) state_d = ST_TRACK;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        hit_ok    = 1'b0;
        exit_path = 1'b0;
        unique case (state_q)
            ST_EMPTY: hit_ok = 1'b0;
            ST_TRACK: hit_ok = elig_hit;
            ST_LOOP:  exit_path = 1'b1;
            default:  hit_ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_flag <= 1'b0;
            vec_addr <= '0;
        end else begin
            vec_flag <= disp && hit_ok;
            if (disp && hit_ok) begin
                vec_addr <= fetch_addr;
            end
        end
    end
endmodule

// File: rtl/trace_repeat_detect.sv
module trace_repeat_detect #(
    parameter int ADDR_W     = 32,
    parameter int BR_W       = 4,
    parameter int HIST_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [BR_W-1:0]   fetch_br,
    input  logic              fetch_bwd_start,
    input  logic              fetch_bwd_end,
    input  logic              dispatch,
    output logic              repeat_hit,
    output logic              vec_flag,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              exit_path,
    output logic              oldest_valid,
    output logic [ADDR_W-1:0] oldest_addr,
    output logic [BR_W-1:0]   oldest_br
);
    logic              disp;
    logic              new_valid;
    logic [ADDR_W-1:0] new_addr;
    logic [BR_W-1:0]   new_br;
    logic              same_key;
    logic              elig_hit;

    assign disp = fetch_valid && dispatch;

    trd_history #(
        .ADDR_W(ADDR_W), .BR_W(BR_W), .DEPTH(HIST_DEPTH)
    ) u_hist (
        .clk(clk), .rst_n(rst_n), .shift_en(disp),
        .in_addr(fetch_addr), .in_br(fetch_br),
        .new_valid(new_valid), .new_addr(new_addr), .new_br(new_br),
        .old_valid(oldest_valid), .old_addr(oldest_addr), .old_br(oldest_br)
    );

    trd_match #(
        .ADDR_W(ADDR_W), .BR_W(BR_W)
    ) u_match (
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_br(fetch_br),
        .bwd_start(fetch_bwd_start), .bwd_end(fetch_bwd_end),
        .ent_valid(new_valid), .ent_addr(new_addr), .ent_br(new_br),
        .same_key(same_key), .elig_hit(elig_hit)
    );

    trd_ctrl #(
        .ADDR_W(ADDR_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .disp(disp),
        .same_key(same_key), .elig_hit(elig_hit), .fetch_addr(fetch_addr),
        .hit_ok(repeat_hit), .exit_path(exit_path),
        .vec_flag(vec_flag), .vec_addr(vec_addr)
    );
endmodule

// File: rtl/trace_repeat_detect_chk.sv
module trace_repeat_detect_chk #(
    parameter int ADDR_W = 32,
    parameter int BR_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid,
    input logic              fetch_bwd_start,
    input logic              fetch_bwd_end,
    input logic              dispatch,
    input logic              repeat_hit,
    input logic              vec_flag,
    input logic              exit_path,
    input logic              oldest_valid,
    input logic [ADDR_W-1:0] oldest_addr,
    input logic [BR_W-1:0]   oldest_br
);
    p_hit_needs_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        repeat_hit |-> fetch_valid);

    p_hit_needs_bounds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        repeat_hit |-> (fetch_bwd_start && fetch_bwd_end));

    p_vec_follows_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && dispatch && repeat_hit) |=> vec_flag);

    p_vec_sets_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_flag |-> exit_path);

    p_no_hit_in_loop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exit_path |-> !repeat_hit);

    p_vec_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_flag |=> !vec_flag);

    p_hist_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_valid && dispatch) |=>
            ($stable(oldest_valid) && $stable(oldest_addr) && $stable(oldest_br)));
endmodule

bind trace_repeat_detect trace_repeat_detect_chk #(
    .ADDR_W(ADDR_W), .BR_W(BR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
    .fetch_bwd_start(fetch_bwd_start), .fetch_bwd_end(fetch_bwd_end),
    .dispatch(dispatch), .repeat_hit(repeat_hit), .vec_flag(vec_flag),
    .exit_path(exit_path), .oldest_valid(oldest_valid),
    .oldest_addr(oldest_addr), .oldest_br(oldest_br)
);

// File: tb/trace_repeat_detect_tb.sv
`timescale 1ns/1ps
module trace_repeat_detect_tb;
    localparam int AW = 4;
    localparam int BW = 2;
    localparam int DP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_valid = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic [BW-1:0] fetch_br = '0;
    logic          fetch_bwd_start = 1'b0;
    logic          fetch_bwd_end = 1'b0;
    logic          dispatch = 1'b0;
    logic          repeat_hit;
    logic          vec_flag;
    logic [AW-1:0] vec_addr;
    logic          exit_path;
    logic          oldest_valid;
    logic [AW-1:0] oldest_addr;
    logic [BW-1:0] oldest_br;

    int checks = 0;
    int failures = 0;

    // model state
    logic          mv [DP];
    logic [AW-1:0] ma [DP];
    logic [BW-1:0] mb [DP];
    logic          mloop;

    always #2.5 clk = ~clk;

    trace_repeat_detect #(.ADDR_W(AW), .BR_W(BW), .HIST_DEPTH(DP)) u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .fetch_br(fetch_br),
        .fetch_bwd_start(fetch_bwd_start), .fetch_bwd_end(fetch_bwd_end),
        .dispatch(dispatch), .repeat_hit(repeat_hit), .vec_flag(vec_flag),
        .vec_addr(vec_addr), .exit_path(exit_path), .oldest_valid(oldest_valid),
        .oldest_addr(oldest_addr), .oldest_br(oldest_br)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [AW-1:0] a, input logic [BW-1:0] b,
                        input logic s, input logic e, input logic d, input string tag);
        logic exp_hit, raw, exp_vec;
        @(negedge clk);
        fetch_valid = v; fetch_addr = a; fetch_br = b;
        fetch_bwd_start = s; fetch_bwd_end = e; dispatch = d;
        raw = v && mv[0] && (a == ma[0]) && (b == mb[0]);
        exp_hit = raw && s && e && !mloop;
        #1;
        chk(tag, {7'd0, repeat_hit}, {7'd0, exp_hit});
        exp_vec = v && d && exp_hit;
        if (v && d) begin
            if (mloop) mloop = raw;
            else mloop = exp_hit;
            for (int i = DP - 1; i > 0; i--) begin
                mv[i] = mv[i-1]; ma[i] = ma[i-1]; mb[i] = mb[i-1];
            end
            mv[0] = 1'b1; ma[0] = a; mb[0] = b;
        end
        @(posedge clk);
        #1;
        chk("R8 vec_flag", {7'd0, vec_flag}, {7'd0, exp_vec});
        if (exp_vec) chk("R8 vec_addr", {4'd0, vec_addr}, {4'd0, a});
        chk("R9 exit_path", {7'd0, exit_path}, {7'd0, mloop});
        chk((v && d) ? "R2 oldest_valid" : "R3 oldest_valid",
            {7'd0, oldest_valid}, {7'd0, mv[DP-1]});
        if (mv[DP-1]) begin
            chk((v && d) ? "R2 oldest_addr" : "R3 oldest_addr",
                {4'd0, oldest_addr}, {4'd0, ma[DP-1]});
            chk((v && d) ? "R2 oldest_br" : "R3 oldest_br",
                {6'd0, oldest_br}, {6'd0, mb[DP-1]});
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < DP; i++) begin
            mv[i] = 1'b0; ma[i] = '0; mb[i] = '0;
        end
        mloop = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 oldest_valid", {7'd0, oldest_valid}, 8'd0);
        chk("R1 vec_flag", {7'd0, vec_flag}, 8'd0);
        chk("R1 exit_path", {7'd0, exit_path}, 8'd0);
        chk("R1 repeat_hit", {7'd0, repeat_hit}, 8'd0);
        // R1: eligible fetch into empty history gives no hit
        step(1, 4'h5, 2'd1, 1, 1, 0, "R1 empty-history hit");

        // R7: match only against the newest entry
        step(1, 4'h3, 2'd0, 1, 1, 1, "R7 seed");
        step(1, 4'h9, 2'd2, 1, 1, 1, "R7 seed");
        step(1, 4'h3, 2'd0, 1, 1, 0, "R7 older-entry probe");
        step(1, 4'h3, 2'd0, 1, 1, 1, "R7 older-entry dispatch");

        // R3: idle cycles leave history untouched
        for (int k = 0; k < 4; k++) step(0, 4'hF, 2'd3, 1, 1, 1, "R3 idle");
        step(1, 4'h9, 2'd2, 1, 1, 0, "R3 fetch no dispatch");

        // exhaustive sweep over address and branch bits
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 4; b++) begin
                logic [AW-1:0] ad;
                logic [BW-1:0] bd;
                ad = a[AW-1:0];
                bd = b[BW-1:0];
                step(1, ad ^ 4'hA, bd, 0, 0, 1, "R2 foreign dispatch");
                step(1, ad, bd, 1, 1, 1, "R2 record");
                step(1, ad ^ 4'h1, bd, 1, 1, 0, "R5 addr differs");
                step(1, ad, bd ^ 2'd1, 1, 1, 0, "R5 branch bit differs");
                step(1, ad, bd, 0, 1, 0, "R6 start flag low");
                step(1, ad, bd, 1, 0, 0, "R6 end flag low");
                step(0, ad, bd, 1, 1, 0, "R10 fetch invalid");
                step(1, ad, bd, 1, 1, 1, "R4 eligible repeat");
                step(1, ad, bd, 1, 1, 1, "R9 same trace in loop");
                step(1, ad, bd, 1, 1, 1, "R9 same trace again");
                step(1, ad ^ 4'h6, bd, 1, 1, 1, "R9 exit trace");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule